// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block produces a single active-low reset request for a host processor. Three sources can hold it low. The first is a hold delay after power-up. The second is a flag from an external comparator that reports the supply is below its trip level. The third is a watchdog timer that the host must service. All timing runs off a tick input. The tick is one pulse per period of a 32.768 kHz crystal, or a slower rate when the periods are scaled down. The nominal hold and pulse time is 8192 ticks, which is 250 ms.

The host picks the watchdog period with a 2-bit select and restarts the count with a one-cycle kick pulse. When the count runs out, the block drives a reset pulse of fixed length and raises a status flag for the length of that pulse. The synchronous `rst` input stands for the power-up event. The parameter `SCALE_SHIFT` shortens every period by a power of two and keeps the ratios between them.

Top module: `supv_reset_gen`

## Requirements
- R1: After `rst`, `host_rst_n_o` is 0 (active low) and stays 0 until 8192>>SCALE_SHIFT ticks have been seen with the supply flag clear. It goes to 1 in the cycle after the edge that takes the last of those ticks.
- R2: When `supply_low_i` is 1 at a clock edge, `host_rst_n_o` is 0 after that edge and the full hold count of R1 restarts from zero.
- R3: The period select `wdt_sel_i` gives these timeouts in ticks before scaling: code 0 gives 57344 (1.75 s), code 1 gives 24576 (750 ms), code 2 gives 8192 (250 ms). Each is shifted right by SCALE_SHIFT. Counting starts from release, kick or select change.
- R4: Code 3 of `wdt_sel_i` disables the watchdog, so `wdt_expired_o` never rises while that code is applied.
- R5: A kick (`wdt_kick_i`=1 at an edge while running) restarts the watchdog count from zero.
- R6: A change of `wdt_sel_i` between two edges restarts the watchdog count from zero.
- R7: On expiry, `host_rst_n_o` is 0 and `wdt_expired_o` is 1 for exactly 8192>>SCALE_SHIFT ticks. After that both outputs return to the running values (1 and 0).
- R8: While reset is asserted, the watchdog count is held at zero. It first advances on a tick after release.
- R9: A supply-low event during a watchdog reset pulse clears `wdt_expired_o`. The full R1 hold delay then applies after the supply recovers.
- R10: `SCALE_SHIFT` divides every period by 2^SCALE_SHIFT. With a shift of 10, the hold, the pulse and the three timeouts are 8, 8, 56, 24 and 8 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| tick_i | input | 1 | Timebase tick, one pulse per counted period |
| supply_low_i | input | 1 | Supply below trip level |
| wdt_kick_i | input | 1 | Watchdog restart pulse |
| wdt_sel_i | input | 2 | Watchdog period select (3 = off) |
| host_rst_n_o | output | 1 | Reset request to host, active low, registered |
| wdt_expired_o | output | 1 | High during a watchdog-caused reset pulse, registered |

## Verification
Every input is sampled at a clock edge. Both outputs are registered, so any effect of a stimulus appears one edge later. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, one edge after the stimulus.

Durations are measured with the tick held high, so they are counted in edges. The hold, the pulse and each timeout must each take exactly their tick count of edges, counted from the sample where the previous state was last seen.

A bench model, stepped on each rising edge with the same inputs, predicts both outputs for every cycle. This covers a random phase with sparse ticks and with kicks, select changes and supply dips mixed in.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // nominal tick counts at 32.768 kHz
  localparam int unsigned NOM_HOLD_TICKS = 8192;   // 250 ms
  localparam int unsigned NOM_WD_LONG    = 57344;  // 1.75 s
  localparam int unsigned NOM_WD_MID     = 24576;  // 750 ms
  localparam int unsigned NOM_WD_SHORT   = 8192;   // 250 ms
  localparam logic [1:0]  WD_SEL_OFF     = 2'd3;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,   // power-up / supply recovery hold
    ST_RUN   = 2'd1,   // reset released, watchdog active
    ST_WDPLS = 2'd2    // watchdog reset pulse
  } supv_state_e;
endpackage

// File: rtl/supv_tick_cnt.sv
module supv_tick_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done,
  output logic [CW-1:0] count
);
  logic [CW-1:0] last;

  assign last = limit - 1'b1;
  assign done = tick && !clr && (count == last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (tick) begin
      count <= done ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/supv_wd_period.sv
module supv_wd_period #(
  parameter int CW          = 16,
  parameter int SCALE_SHIFT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    sel,
  output logic [CW-1:0] limit,
  output logic          enabled,
  output logic          changed
);
  import supv_pkg::*;

  localparam int unsigned LIM_LONG  = NOM_WD_LONG  >> SCALE_SHIFT;
  localparam int unsigned LIM_MID   = NOM_WD_MID   >> SCALE_SHIFT;
  localparam int unsigned LIM_SHORT = NOM_WD_SHORT >> SCALE_SHIFT;

  logic [1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 2'd0;
    else     sel_q <= sel;
  end

  assign changed = (sel != sel_q);
  assign enabled = (sel != WD_SEL_OFF);

  always_comb begin
    case (sel)
      2'd0:    limit = CW'(LIM_LONG);
      2'd1:    limit = CW'(LIM_MID);
      2'd2:    limit = CW'(LIM_SHORT);
      default: limit = CW'(LIM_SHORT);
    endcase
  end
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int SCALE_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       supply_low_i,
  input  logic       wdt_kick_i,
  input  logic [1:0] wdt_sel_i,
  output logic       host_rst_n_o,
  output logic       wdt_expired_o
);
  import supv_pkg::*;

  localparam int unsigned HOLD_TICKS = NOM_HOLD_TICKS >> SCALE_SHIFT;
  localparam int unsigned MAX_TICKS  = NOM_WD_LONG >> SCALE_SHIFT;
  localparam int          CW         = $clog2(MAX_TICKS + 1);

  supv_state_e   state, nxt;
  logic [CW-1:0] hold_cnt, wd_count, wd_limit;
  logic          hold_done, hold_clr;
  logic          wd_done, wd_clr, wd_en, sel_chg;

  supv_wd_period #(.CW(CW), .SCALE_SHIFT(SCALE_SHIFT)) u_period (
    .clk(clk), .rst(rst), .sel(wdt_sel_i),
    .limit(wd_limit), .enabled(wd_en), .changed(sel_chg)
  );

  // shared by the power-up hold and the watchdog pulse (equal lengths)
  assign hold_clr = (state == ST_RUN) || supply_low_i;
  supv_tick_cnt #(.CW(CW)) u_hold (
    .clk(clk), .rst(rst), .clr(hold_clr), .tick(tick_i),
    .limit(CW'(HOLD_TICKS)), .done(hold_done), .count(hold_cnt)
  );

  assign wd_clr = (state != ST_RUN) || !wd_en || wdt_kick_i || sel_chg;
  supv_tick_cnt #(.CW(CW)) u_wd (
    .clk(clk), .rst(rst), .clr(wd_clr), .tick(tick_i),
    .limit(wd_limit), .done(wd_done), .count(wd_count)
  );

  always_comb begin
    nxt = state;
    if (supply_low_i) begin
      nxt = ST_HOLD;
    end else begin
      case (state)
        ST_HOLD:  if (hold_done) nxt = ST_RUN;
        ST_RUN:   if (wd_done)   nxt = ST_WDPLS;
        ST_WDPLS: if (hold_done) nxt = ST_RUN;
        default:  nxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_HOLD;
      host_rst_n_o  <= 1'b0;
      wdt_expired_o <= 1'b0;
    end else begin
      state         <= nxt;
      host_rst_n_o  <= (nxt == ST_RUN);
      wdt_expired_o <= (nxt == ST_WDPLS);
    end
  end
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          supply_low_i,
  input logic [1:0]    wdt_sel_i,
  input logic          host_rst_n_o,
  input logic          wdt_expired_o,
  input logic [CW-1:0] wd_count
);
  assert_supply_resets_R2: assert property (@(posedge clk) disable iff (rst)
    supply_low_i |=> !host_rst_n_o);

  assert_expired_in_reset_R7: assert property (@(posedge clk) disable iff (rst)
    wdt_expired_o |-> !host_rst_n_o);

  assert_expiry_from_run_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_expired_o) |-> $past(host_rst_n_o));

  assert_off_never_expires_R4: assert property (@(posedge clk) disable iff (rst)
    (host_rst_n_o && wdt_sel_i == 2'd3) |=> !wdt_expired_o);

  assert_wd_held_in_reset_R8: assert property (@(posedge clk) disable iff (rst)
    (!host_rst_n_o && $past(!host_rst_n_o)) |-> (wd_count == '0));

  assert_release_needs_supply_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rst_n_o) |-> $past(!supply_low_i));
endmodule

bind supv_reset_gen supv_reset_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .supply_low_i(supply_low_i), .wdt_sel_i(wdt_sel_i),
  .host_rst_n_o(host_rst_n_o), .wdt_expired_o(wdt_expired_o), .wd_count(wd_count)
);

// File: tb/test_supv_reset_gen.sv
module test_supv_reset_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SHIFT      = 10;
  localparam int HOLD_T     = 8192 >> SHIFT;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 1'b1, supply = 1'b0, kick = 1'b0;
  logic [1:0] sel = 2'd2;
  logic rst_n, expired;
  int checks = 0, errors = 0;

  // model state
  int m_st = 0, m_hold = 0, m_wd = 0;
  logic [1:0] m_selp = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_reset_gen #(.SCALE_SHIFT(SHIFT)) i_supv_reset_gen (
    .clk(clk), .rst(rst), .tick_i(tick), .supply_low_i(supply),
    .wdt_kick_i(kick), .wdt_sel_i(sel),
    .host_rst_n_o(rst_n), .wdt_expired_o(expired)
  );

  function automatic int wd_ticks(input logic [1:0] s);
    case (s)
      2'd0:    return 57344 >> SHIFT;
      2'd1:    return 24576 >> SHIFT;
      default: return 8192 >> SHIFT;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit chg;
    chg = (sel != m_selp);
    m_selp = sel;
    if (rst) begin
      m_st = 0; m_hold = 0; m_wd = 0; m_selp = 2'd0;
    end else if (supply) begin
      m_st = 0; m_hold = 0; m_wd = 0;
    end else if (m_st == 0) begin
      m_wd = 0;
      if (tick) begin
        if (m_hold == HOLD_T-1) begin m_st = 1; m_hold = 0; end
        else m_hold++;
      end
    end else if (m_st == 1) begin
      if (sel == 2'd3 || kick || chg) m_wd = 0;
      else if (tick) begin
        if (m_wd == wd_ticks(sel)-1) begin m_st = 2; m_wd = 0; end
        else m_wd++;
      end
    end else begin
      m_wd = 0;
      if (tick) begin
        if (m_hold == HOLD_T-1) begin m_st = 1; m_hold = 0; end
        else m_hold++;
      end
    end
  endtask

  // one clock: model steps at the edge, compare at the falling edge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(rst_n == (m_st == 1), tag, rst_n, (m_st == 1));
    chk(expired == (m_st == 2), tag, expired, (m_st == 2));
  endtask

  task automatic count_edges(input bit use_exp, input logic val, input string tag, output int n);
    n = 0;
    while (((use_exp ? expired : rst_n) == val) && n < 100000) begin
      cyc(tag);
      n++;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    @(negedge clk);
    cyc("R1_reset");
    rst = 1'b0;
    chk(rst_n == 1'b0, "R1_reset_state", rst_n, 0);
    chk(expired == 1'b0, "R1_reset_state", expired, 0);
    count_edges(1'b0, 1'b0, "R1", n);
    chk(n == HOLD_T, "R1 R10 hold length", n, HOLD_T);

    // R3: each period, measured from release, kick or select change
    count_edges(1'b1, 1'b0, "R3", n);
    chk(n == wd_ticks(2'd2), "R3 R10 period sel2", n, wd_ticks(2'd2));
    count_edges(1'b1, 1'b1, "R7", n);
    chk(n == HOLD_T, "R7 pulse length", n, HOLD_T);
    chk(rst_n == 1'b1, "R7 release after pulse", rst_n, 1);

    // R6: select change restarts the count with the new period
    repeat (3) cyc("R6");
    sel = 2'd1;
    cyc("R6");
    count_edges(1'b1, 1'b0, "R6", n);
    chk(n == wd_ticks(2'd1), "R6 restart on select change", n, wd_ticks(2'd1));
    count_edges(1'b1, 1'b1, "R7", n);

    sel = 2'd0;
    cyc("R3");
    count_edges(1'b1, 1'b0, "R3", n);
    chk(n == wd_ticks(2'd0), "R3 period sel0", n, wd_ticks(2'd0));
    count_edges(1'b1, 1'b1, "R7", n);

    // R5: kick restarts
    sel = 2'd2;
    cyc("R5");
    repeat (5) cyc("R5");
    kick = 1'b1; cyc("R5"); kick = 1'b0;
    count_edges(1'b1, 1'b0, "R5", n);
    chk(n == wd_ticks(2'd2), "R5 restart on kick", n, wd_ticks(2'd2));

    // R9: supply dip during the watchdog pulse
    repeat (2) cyc("R9");
    supply = 1'b1; cyc("R9");
    chk(expired == 1'b0, "R9 flag cleared", expired, 0);
    chk(rst_n == 1'b0, "R2 supply low resets", rst_n, 0);
    cyc("R9"); supply = 1'b0;
    count_edges(1'b0, 1'b0, "R9", n);
    chk(n == HOLD_T, "R9 full hold after recovery", n, HOLD_T);

    // R4: disabled watchdog never fires
    sel = 2'd3;
    n = 0;
    repeat (200) begin
      cyc("R4");
      if (expired) n++;
    end
    chk(n == 0, "R4 disabled", n, 0);

    // R2: supply dip while running restarts the full hold
    supply = 1'b1; cyc("R2"); supply = 1'b0;
    count_edges(1'b0, 1'b0, "R2", n);
    chk(n == HOLD_T, "R2 hold restart", n, HOLD_T);

    // random phase against the model
    for (int i = 0; i < 20000; i++) begin
      tick   = ($urandom % 3) != 0;
      kick   = ($urandom % 40) == 0;
      supply = ($urandom % 500) == 0;
      if (($urandom % 300) == 0) sel = 2'($urandom);
      cyc("R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout R1 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule